// File: doc/BRIEF.md
# Audio Serial Transmit Encoder (Master Mode)

This block drives the transmit side of a stereo/multichannel audio serial link as the clock master. It runs from the audio master clock. From that clock it makes a bit clock and a word-select (frame) clock, and a frame is always 64 bit clocks long. Interleaved PCM samples arrive over a valid/ready sample port. The block shifts them out most-significant bit first. Each half-frame is a 32-bit slot that carries either a full 32-bit word or a 16-bit sample followed by zero padding. The link carries 2 channels, or 8 channels spread over four successive frames.

A small write-only register port sets the run enable, one of two divider modes, clock polarities and a data skew of 0 to 3 bit clocks. A skew of 0 gives left-justified framing. A skew of 1 together with an inverted word select gives the classic I2S framing. The sample format is written to a staging register. It only reaches the datapath when a soft-reset command is issued, and that command also flushes the sample pipeline.

Register map (address on `cfg_addr`, data on `cfg_wdata`):
- Address 0, control: bit0 run, bit1 extended-divider select, bits[3:2] log2 of the legacy ratio, bit4 bit-clock invert, bit5 word-select invert, bits[7:6] skew.
- Address 1, extended divider: bits[5:0] hold the ratio minus one.
- Address 2, staged format: bit0 eight-channel, bits[1] and [2] both set for 32-bit data.
- Address 3, command: bit0 soft reset, bit1 clear underflow.

Top module: `i2s_tx_encoder`

## Requirements
- R1: After reset, and while control bit0 (run) is clear, bclk_o equals control bit4, ws_o equals control bit5, sd_o is 0 and s_ready stays low. After reset all registers are zero.
- R2: With control bit1 clear, each bit-clock phase lasts 2^(control[3:2]) master cycles, so the bit-clock period is 2, 4, 8 or 16 cycles.
- R3: With control bit1 set, each bit-clock phase lasts (extended[5:0] + 1) master cycles, from 1 up to 64.
- R4: A frame is 64 bit clocks long. With control bit5 clear, word select is high for the first 32 bit clocks and low for the last 32. Setting control bit5 inverts it. It changes only on a falling bit-clock edge.
- R5: Control bit4 inverts the bit-clock pin. Data and word select change on the falling edge of the non-inverted bit clock and are stable at its rising edge.
- R6: Slot data starts skew = control[7:6] bit clocks after the frame (or half-frame) edge and is sent most-significant bit first.
- R7: When format bits 1 and 2 are both set, each slot carries all 32 data bits. Otherwise it carries s_data[15:0] followed by 16 zero bits.
- R8: s_ready is a one-cycle pulse, issued once per half-frame during the last bit of the preceding slot. The sample is taken in that cycle if s_valid is high.
- R9: s_chan gives the channel of the requested sample. In 2-channel mode it alternates 0,1. With format bit0 set it runs 0 through 7 and repeats.
- R10: A request without s_valid sends an all-zero slot and sets underflow_o. The flag stays set until a command write with bit1 set, and a new underflow in the same cycle wins.
- R11: A format write has no effect until a soft-reset command. The soft reset applies the staged format, empties the sample pipeline and restarts the channel sequence.
- R12: After run is set, the first request is for channel 0. Every bit before the first fetched sample is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| s_valid | input | 1 | Sample present |
| s_data | input | 32 | Sample word (low 16 bits used in 16-bit slots) |
| s_ready | output | 1 | One-cycle sample request |
| s_chan | output | 3 | Channel index of the requested sample |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word-select (frame) clock |
| sd_o | output | 1 | Serial data |
| underflow_o | output | 1 | Sticky missing-sample flag |

## Verification
Two things are hard to reach from the pins. One is the staged format, which must survive a format write that is not followed by a soft reset. The other is the serial position of each bit under every skew. To cover both, each run programs the registers, enables the block and captures sd_o and ws_o at every rising logical bit-clock edge. The bench then rebuilds the expected stream from the samples it actually handed over, counting zeros for every request it randomly declined. One run writes a new format without the command and checks the stream against the old format. The following run applies the command and checks the new format.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam int XDIV_W = 6;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_XDIV = 2'd1;
  localparam logic [1:0] ADDR_FMT  = 2'd2;
  localparam logic [1:0] ADDR_CMD  = 2'd3;

  typedef struct packed {
    logic [1:0]        skew;
    logic              ws_inv;
    logic              bclk_inv;
    logic [1:0]        lg2_div;
    logic              xdiv_sel;
    logic              run;
    logic [XDIV_W-1:0] xdiv_m1;
  } tx_cfg_t;

  typedef struct packed {
    logic ch8;
    logic wide;
  } tx_fmt_t;
endpackage

// File: rtl/i2s_tx_regs.sv
module i2s_tx_regs
  import i2s_tx_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [CFG_W-1:0] wdata,
  output tx_cfg_t          cfg,
  output tx_fmt_t          fmt_act,
  output logic             soft_rst,
  output logic             uf_clr
);
  tx_fmt_t fmt_stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg       <= '0;
      fmt_stage <= '0;
      fmt_act   <= '0;
      soft_rst  <= 1'b0;
      uf_clr    <= 1'b0;
    end else begin
      soft_rst <= 1'b0;
      uf_clr   <= 1'b0;
      if (we) begin
        case (addr)
          ADDR_CTRL: begin
            cfg.run      <= wdata[0];
            cfg.xdiv_sel <= wdata[1];
            cfg.lg2_div  <= wdata[3:2];
            cfg.bclk_inv <= wdata[4];
            cfg.ws_inv   <= wdata[5];
            cfg.skew     <= wdata[7:6];
          end
          ADDR_XDIV: cfg.xdiv_m1 <= wdata[XDIV_W-1:0];
          ADDR_FMT: begin
            fmt_stage.ch8  <= wdata[0];
            fmt_stage.wide <= wdata[1] & wdata[2];
          end
          default: begin
            soft_rst <= wdata[0];
            uf_clr   <= wdata[1];
            if (wdata[0]) fmt_act <= fmt_stage;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2s_tx_bitclk.sv
module i2s_tx_bitclk #(
  parameter int XDIV_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              xdiv_sel,
  input  logic [1:0]        lg2_div,
  input  logic [XDIV_W-1:0] xdiv_m1,
  input  logic              bclk_inv,
  output logic              tick,
  output logic              ph,
  output logic              bclk_o
);
  logic [XDIV_W-1:0] cnt;
  logic [XDIV_W-1:0] ratio_m1;

  always_comb begin
    if (xdiv_sel) ratio_m1 = xdiv_m1;
    else          ratio_m1 = XDIV_W'((1 << lg2_div) - 1);
  end

  assign tick = run && (cnt == ratio_m1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt    <= '0;
      ph     <= 1'b1;
      bclk_o <= bclk_inv;
    end else if (tick) begin
      cnt    <= '0;
      ph     <= ~ph;
      bclk_o <= (~ph) ^ bclk_inv;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer #(
  parameter int SLOT_W   = 32,
  parameter int CH_PAIRS = 4
) (
  input  logic                  clk,
  input  logic                  rst_hard,
  input  logic                  rst,
  input  logic                  run,
  input  logic                  tick,
  input  logic                  ph,
  input  logic [1:0]            skew,
  input  logic                  ws_inv,
  input  logic                  wide,
  input  logic                  ch8,
  input  logic                  uf_clr,
  input  logic                  s_valid,
  input  logic [SLOT_W-1:0]     s_data,
  output logic                  s_ready,
  output logic [$clog2(CH_PAIRS):0] s_chan,
  output logic                  sd_o,
  output logic                  ws_o,
  output logic                  underflow
);
  localparam int FRAME = 2 * SLOT_W;
  localparam int BW    = $clog2(FRAME);
  localparam int KW    = $clog2(SLOT_W);
  localparam int PW    = $clog2(CH_PAIRS);
  localparam int HALF  = SLOT_W / 2;

  logic [BW-1:0]     bit_q, nb, np;
  logic [KW-1:0]     k, idx_w, idx_n;
  logic [SLOT_W-1:0] cur, nxt, word;
  logic              fall, slot_start, bit_val, half_q;
  logic [PW-1:0]     pair;

  assign fall       = run && tick && ph;
  assign nb         = bit_q + 1'b1;
  assign np         = nb - BW'(skew);
  assign k          = np[KW-1:0];
  assign slot_start = (k == '0);
  assign word       = slot_start ? nxt : cur;
  assign idx_w      = KW'(SLOT_W - 1) - k;
  assign idx_n      = KW'(HALF - 1) - k;

  always_comb begin
    if (wide)                  bit_val = word[idx_w];
    else if (k < KW'(HALF))    bit_val = word[idx_n];
    else                       bit_val = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      bit_q   <= BW'(FRAME - 2);
      cur     <= '0;
      nxt     <= '0;
      sd_o    <= 1'b0;
      ws_o    <= ws_inv;
      s_ready <= 1'b0;
      half_q  <= 1'b0;
      pair    <= '0;
    end else begin
      s_ready <= 1'b0;
      if (fall) begin
        bit_q <= nb;
        sd_o  <= bit_val;
        ws_o  <= (~nb[BW-1]) ^ ws_inv;
        if (slot_start) cur <= nxt;
        if (k == KW'(SLOT_W - 1)) begin
          s_ready <= 1'b1;
          half_q  <= ~np[BW-1];
        end
      end
      if (s_ready) begin
        nxt <= s_valid ? s_data : '0;
        if (half_q) begin
          if (!ch8 || pair == PW'(CH_PAIRS - 1)) pair <= '0;
          else                                    pair <= pair + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_hard)                          underflow <= 1'b0;
    else if (s_ready && run && !s_valid)   underflow <= 1'b1;
    else if (uf_clr)                       underflow <= 1'b0;
  end

  assign s_chan = {pair, half_q};
endmodule

// File: rtl/i2s_tx_encoder.sv
module i2s_tx_encoder
  import i2s_tx_pkg::*;
#(
  parameter int SLOT_W   = 32,
  parameter int CFG_W    = 8,
  parameter int CH_PAIRS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_we,
  input  logic [1:0]                  cfg_addr,
  input  logic [CFG_W-1:0]            cfg_wdata,
  input  logic                        s_valid,
  input  logic [SLOT_W-1:0]           s_data,
  output logic                        s_ready,
  output logic [$clog2(CH_PAIRS):0]   s_chan,
  output logic                        bclk_o,
  output logic                        ws_o,
  output logic                        sd_o,
  output logic                        underflow_o
);
  tx_cfg_t cfg;
  tx_fmt_t fmt_act;
  logic    soft_rst, uf_clr, core_rst, tick, ph;

  assign core_rst = rst | soft_rst;

  i2s_tx_regs #(.CFG_W(CFG_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .cfg(cfg), .fmt_act(fmt_act), .soft_rst(soft_rst), .uf_clr(uf_clr)
  );

  i2s_tx_bitclk #(.XDIV_W(XDIV_W)) u_bclk (
    .clk(clk), .rst(core_rst), .run(cfg.run), .xdiv_sel(cfg.xdiv_sel),
    .lg2_div(cfg.lg2_div), .xdiv_m1(cfg.xdiv_m1), .bclk_inv(cfg.bclk_inv),
    .tick(tick), .ph(ph), .bclk_o(bclk_o)
  );

  i2s_tx_serializer #(.SLOT_W(SLOT_W), .CH_PAIRS(CH_PAIRS)) u_ser (
    .clk(clk), .rst_hard(rst), .rst(core_rst), .run(cfg.run), .tick(tick),
    .ph(ph), .skew(cfg.skew), .ws_inv(cfg.ws_inv), .wide(fmt_act.wide),
    .ch8(fmt_act.ch8), .uf_clr(uf_clr), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .s_chan(s_chan), .sd_o(sd_o), .ws_o(ws_o),
    .underflow(underflow_o)
  );
endmodule

// File: rtl/i2s_tx_encoder_chk.sv
module i2s_tx_encoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       run,
  input logic       binv,
  input logic       ch8,
  input logic       uf_clr,
  input logic       s_valid,
  input logic       s_ready,
  input logic [2:0] s_chan,
  input logic       bclk_o,
  input logic       sd_o,
  input logic       underflow_o
);
  // R8: request is a single-cycle pulse
  p_ready_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    s_ready |=> !s_ready);

  // R1: no request while stopped
  p_idle_no_req_r1: assert property (@(posedge clk) disable iff (rst)
    (!run && !$past(run)) |-> !s_ready);

  // R1: idle pin levels
  p_idle_pins_r1: assert property (@(posedge clk) disable iff (rst)
    (!run && !$past(run) && $stable(binv)) |-> (sd_o == 1'b0 && bclk_o == binv));

  // R9: two-channel mode only requests channels 0 and 1
  p_two_ch_r9: assert property (@(posedge clk) disable iff (rst)
    (s_ready && !ch8) |-> (s_chan[2:1] == 2'b00));

  // R10: missing sample raises the flag
  p_uf_set_r10: assert property (@(posedge clk) disable iff (rst)
    (s_ready && run && !s_valid) |=> underflow_o);

  // R10: flag holds until cleared
  p_uf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (underflow_o && !uf_clr) |=> underflow_o);

  // R5: data moves only together with a falling logical bit clock
  p_sd_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && $stable(binv) && sd_o != $past(sd_o)) |-> ((bclk_o ^ binv) == 1'b0));
endmodule

bind i2s_tx_encoder i2s_tx_encoder_chk u_chk (
  .clk(clk), .rst(rst), .run(cfg.run), .binv(cfg.bclk_inv), .ch8(fmt_act.ch8),
  .uf_clr(uf_clr), .s_valid(s_valid), .s_ready(s_ready), .s_chan(s_chan),
  .bclk_o(bclk_o), .sd_o(sd_o), .underflow_o(underflow_o)
);

// File: tb/tb_i2s_tx_encoder.sv
module tb_i2s_tx_encoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_ready, bclk_o, ws_o, sd_o, underflow_o;
  logic [2:0]  s_chan;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2s_tx_encoder dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready), .s_chan(s_chan),
    .bclk_o(bclk_o), .ws_o(ws_o), .sd_o(sd_o), .underflow_o(underflow_o)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] sent [0:1023];
  bit          cap_sd [0:1023];
  bit          cap_ws [0:1023];
  int          rise_at [0:1023];
  int          nsent, ncap;
  bit          last_uf;

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  task automatic check(input bit ok, input string req, input longint act,
                       input longint exp, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [7:0] ctrl_byte(input bit run, input bit xsel, input logic [1:0] lg2,
                                           input bit binv, input bit winv, input logic [1:0] skew);
    return {skew, winv, binv, lg2, xsel, run};
  endfunction

  function automatic bit exp_sd(input int j, input int skew, input bit wide);
    int n, idx, k;
    logic [31:0] w;
    n = j - skew - 1;
    if (n < 0) return 1'b0;
    idx = n / 32;
    k = n % 32;
    w = (idx < nsent) ? sent[idx] : 32'h0;
    if (wide) return w[31-k];
    if (k < 16) return w[15-k];
    return 1'b0;
  endfunction

  task automatic run_cfg(input string tag, input bit xsel, input logic [1:0] lg2,
                         input logic [5:0] xd, input bit binv, input bit winv,
                         input logic [1:0] skew, input logic [7:0] fmtw, input bit do_srst,
                         input bit ex_wide, input bit ex_ch8, input int nbits, input int vpct);
    int ratio, nreq, chan_bad, sd_bad, ws_bad, b, fa, fe;
    bit prev_l, l, exp_uf, ews;
    ratio = xsel ? int'(xd) + 1 : (1 << lg2);
    nreq = 0; chan_bad = 0; sd_bad = 0; ws_bad = 0; fa = 0; fe = 0;
    prev_l = 1'b0; exp_uf = 1'b0;
    wr(2'd0, ctrl_byte(1'b0, xsel, lg2, binv, winv, skew));
    wr(2'd1, {2'b00, xd});
    wr(2'd2, fmtw);
    if (do_srst) wr(2'd3, 8'h01);
    wr(2'd3, 8'h02);
    nsent = 0; ncap = 0;
    wr(2'd0, ctrl_byte(1'b1, xsel, lg2, binv, winv, skew));
    while (ncap < nbits) begin
      @(negedge clk);
      l = bclk_o ^ binv;
      if (l && !prev_l) begin
        cap_sd[ncap] = sd_o; cap_ws[ncap] = ws_o; rise_at[ncap] = cyc; ncap++;
      end
      prev_l = l;
      if (s_ready) begin
        if (int'(s_chan) != (ex_ch8 ? nreq % 8 : nreq % 2)) chan_bad++;
        nreq++;
        if (($urandom % 100) < vpct) begin
          s_valid = 1'b1; s_data = $urandom; sent[nsent] = s_data;
        end else begin
          s_valid = 1'b0; sent[nsent] = 32'h0; exp_uf = 1'b1;
        end
        nsent++;
      end else begin
        s_valid = 1'b0;
      end
    end
    check(underflow_o == exp_uf, "R10", underflow_o, exp_uf, {tag, " underflow flag"});
    last_uf = exp_uf;
    wr(2'd0, ctrl_byte(1'b0, xsel, lg2, binv, winv, skew));
    s_valid = 1'b0;
    for (int j = 0; j < nbits; j++) begin
      b = (j + 63) % 64;
      ews = (b < 32) ^ winv;
      if (cap_ws[j] != ews) ws_bad++;
      if (cap_sd[j] != exp_sd(j, skew, ex_wide)) begin
        if (sd_bad == 0) begin fa = cap_sd[j]; fe = exp_sd(j, skew, ex_wide); end
        sd_bad++;
      end
    end
    check(sd_bad == 0, "R6 R7 R11 R12", sd_bad, 0, {tag, " data stream mismatches"});
    check(ws_bad == 0, "R4", ws_bad, 0, {tag, " word select mismatches"});
    check(chan_bad == 0 && nreq > 1, "R8 R9", chan_bad, 0, {tag, " channel order errors"});
    if (nbits >= 4)
      check(rise_at[3] - rise_at[2] == 2 * ratio, xsel ? "R3" : "R2",
            rise_at[3] - rise_at[2], 2 * ratio, {tag, " bit clock period"});
  endtask

  initial begin
    int rdy_seen;
    void'($urandom(32'h1234_5678));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(bclk_o == 1'b0, "R1", bclk_o, 0, "reset bclk");
    check(ws_o == 1'b0, "R1", ws_o, 0, "reset ws");
    check(sd_o == 1'b0, "R1", sd_o, 0, "reset sd");
    check(s_ready == 1'b0, "R1", s_ready, 0, "reset ready");
    check(underflow_o == 1'b0, "R1", underflow_o, 0, "reset underflow");
    // R1, R5, R4: idle levels follow the inversion bits while stopped
    wr(2'd0, ctrl_byte(1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd0));
    rdy_seen = 0;
    repeat (50) begin
      @(negedge clk);
      if (s_ready) rdy_seen++;
    end
    check(bclk_o == 1'b1, "R5", bclk_o, 1, "idle inverted bclk");
    check(ws_o == 1'b1, "R4", ws_o, 1, "idle inverted ws");
    check(rdy_seen == 0, "R1", rdy_seen, 0, "requests while stopped");

    run_cfg("lj16x2",  1'b0, 2'd0, 6'd0,  1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0, 200, 100);
    run_cfg("i2s32x8", 1'b1, 2'd0, 6'd5,  1'b0, 1'b1, 2'd1, 8'h07, 1'b1, 1'b1, 1'b1, 300, 100);
    // R11: format written without soft reset keeps the old 32-bit/8-channel format
    run_cfg("staged",  1'b0, 2'd1, 6'd0,  1'b1, 1'b0, 2'd2, 8'h00, 1'b0, 1'b1, 1'b1, 140, 100);
    run_cfg("uflow",   1'b0, 2'd2, 6'd0,  1'b0, 1'b0, 2'd3, 8'h01, 1'b1, 1'b0, 1'b1, 260, 30);
    // R10: flag sticky after stop, then cleared by command
    check(underflow_o == last_uf, "R10", underflow_o, last_uf, "sticky after stop");
    wr(2'd3, 8'h02);
    repeat (2) @(negedge clk);
    check(underflow_o == 1'b0, "R10", underflow_o, 0, "cleared by command");
    run_cfg("div8",    1'b0, 2'd3, 6'd0,  1'b1, 1'b1, 2'd0, 8'h06, 1'b1, 1'b1, 1'b0, 100, 100);
    run_cfg("xdiv64",  1'b1, 2'd0, 6'd63, 1'b0, 1'b0, 2'd1, 8'h06, 1'b1, 1'b1, 1'b0, 70, 100);
    run_cfg("halfwid", 1'b1, 2'd0, 6'd1,  1'b0, 1'b0, 2'd0, 8'h02, 1'b1, 1'b0, 1'b0, 100, 100);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule